// File: doc/BRIEF.md
# Bus Reset and Presence-Detect Sequencer

This block runs the reset handshake of a single-wire, open-drain device bus so that the host never has to time it. A one-clock start strobe begins the sequence. The block first holds the line low for the reset-low period. It then releases the line to a weak pullup and waits through three timed windows. At the end of the first window it samples the line for a short or an interrupt. At the end of the second it samples for a device presence answer. After a fill delay it reports done together with both flags.

All durations are counted in microsecond ticks. A prescaler parameter derives these ticks from the system clock. The speed mode is captured when the start is accepted, and it chooses between the standard duration set and the overdrive set. The sensed line level passes through a synchronizer before it is sampled. The block makes no assumption about how fast a responding device pulls the line down.

Top module: `bus_reset_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `pullLow`, `pullupEn`, `shortFlag` and `presenceFlag` are all 0.
- R2: A `startReq` seen while idle is accepted at that clock edge. From the next cycle on, `busy` and `pullLow` are 1. `pullLow` stays 1 for exactly lowUs × CLK_PER_US cycles.
- R3: `speedSel` 2'b00 (standard) and 2'b01 (flexible) both use 512/8/64/512 µs for low, short-check, presence-check and fill. `speedSel[1]` = 1 selects overdrive, which uses 64/2/8/64 µs.
- R4: Once `pullLow` falls, `pullupEn` is 1 for exactly (short + presence + fill) µs × CLK_PER_US cycles. `pullLow` and `pullupEn` are never 1 together.
- R5: At the end of the short-check window, `shortFlag` takes the inverse of the synchronized line level. A line that is low two cycles before that edge gives `shortFlag` = 1.
- R6: At the end of the presence-check window, `presenceFlag` takes the inverse of the synchronized line level. A line held low by a device at that point gives `presenceFlag` = 1.
- R7: `done` is 1 for exactly one cycle, the cycle after the fill window ends. In that same cycle `busy` is already 0.
- R8: A `startReq` that arrives while `busy` is 1 has no effect. The running sequence keeps its timing.
- R9: `shortFlag` and `presenceFlag` hold their values after `done` until the next start is accepted. The accepted start clears both in the cycle that follows it.
- R10: The speed mode is captured when the start is accepted. Changing `speedSel` during a sequence does not change any duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe for a reset/presence sequence |
| speedSel | input | 2 | Speed mode: 00 standard, 01 flexible, 1x overdrive |
| busIn | input | 1 | Sensed bus line level |
| pullLow | output | 1 | Enable for the open-drain pull-down |
| pullupEn | output | 1 | Enable for the weak pullup during the release windows |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| shortFlag | output | 1 | Short or interrupt seen at the first sample |
| presenceFlag | output | 1 | Device presence seen at the second sample |

## Verification
A wrong state or counter value in this block shows up at the ports within one segment. The pull-down or pullup window becomes longer or shorter than the required number of cycles, and the bench counts those windows to the exact clock. An error in the sample strobes shows up as a wrong flag once `done` pulses. A missed clear shows up in the cycle right after a start. A mis-latched speed mode changes the length of the very first low window. Each error is therefore visible within one sequence, and usually within the segment where it happens.

// File: rtl/bus_reset_pkg.sv
package bus_reset_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_SHORT_WAIT,
    ST_PRES_WAIT,
    ST_FILL
  } seqState_t;

  typedef struct packed {
    logic restartTimer;
    logic clearFlags;
    logic sampleShort;
    logic samplePresence;
  } dpStrobe_t;

endpackage

// File: rtl/bus_reset_ctrl.sv
module bus_reset_ctrl
  import bus_reset_pkg::*;
#(
  parameter int DUR_W       = 10,
  parameter int STD_LOW_US  = 512,
  parameter int STD_SI_US   = 8,
  parameter int STD_PDT_US  = 64,
  parameter int STD_FILL_US = 512,
  parameter int OD_LOW_US   = 64,
  parameter int OD_SI_US    = 2,
  parameter int OD_PDT_US   = 8,
  parameter int OD_FILL_US  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [1:0]       speedSel,
  input  logic             segDone,
  output dpStrobe_t        strb,
  output logic [DUR_W-1:0] segLen,
  output logic             busy,
  output logic             pullLow,
  output logic             pullupEn,
  output logic             done
);

  localparam logic [DUR_W-1:0] STD_LOW  = DUR_W'(STD_LOW_US);
  localparam logic [DUR_W-1:0] STD_SI   = DUR_W'(STD_SI_US);
  localparam logic [DUR_W-1:0] STD_PDT  = DUR_W'(STD_PDT_US);
  localparam logic [DUR_W-1:0] STD_FILL = DUR_W'(STD_FILL_US);
  localparam logic [DUR_W-1:0] OD_LOW   = DUR_W'(OD_LOW_US);
  localparam logic [DUR_W-1:0] OD_SI    = DUR_W'(OD_SI_US);
  localparam logic [DUR_W-1:0] OD_PDT   = DUR_W'(OD_PDT_US);
  localparam logic [DUR_W-1:0] OD_FILL  = DUR_W'(OD_FILL_US);

  seqState_t state, stateNext;
  logic      odLatched;
  logic      doneNext;

  // Next-state logic and strobes sent to the datapath
  always_comb begin
    stateNext = state;
    strb      = '0;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stateNext         = ST_LOW;
        strb.restartTimer = 1'b1;
        strb.clearFlags   = 1'b1;
      end
      ST_LOW: if (segDone) begin
        stateNext         = ST_SHORT_WAIT;
        strb.restartTimer = 1'b1;
      end
      ST_SHORT_WAIT: if (segDone) begin
        stateNext         = ST_PRES_WAIT;
        strb.restartTimer = 1'b1;
        strb.sampleShort  = 1'b1;
      end
      ST_PRES_WAIT: if (segDone) begin
        stateNext           = ST_FILL;
        strb.restartTimer   = 1'b1;
        strb.samplePresence = 1'b1;
      end
      ST_FILL: if (segDone) begin
        stateNext = ST_IDLE;
        doneNext  = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // Length of the running segment, picked by the captured speed mode
  always_comb begin
    unique case (state)
      ST_SHORT_WAIT: segLen = odLatched ? OD_SI   : STD_SI;
      ST_PRES_WAIT:  segLen = odLatched ? OD_PDT  : STD_PDT;
      ST_FILL:       segLen = odLatched ? OD_FILL : STD_FILL;
      default:       segLen = odLatched ? OD_LOW  : STD_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      odLatched <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
      if (state == ST_IDLE && startReq) odLatched <= speedSel[1];
    end
  end

  assign busy     = (state != ST_IDLE);
  assign pullLow  = (state == ST_LOW);
  assign pullupEn = busy && !pullLow;

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_drive_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(pullLow && pullupEn));
  assert_release_to_pullup_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pullLow) |-> pullupEn);
  assert_speed_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(odLatched));
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !pullLow && startReq) |=> !pullLow);

endmodule

// File: rtl/bus_reset_dp.sv
module bus_reset_dp
  import bus_reset_pkg::*;
#(
  parameter int CLK_PER_US  = 200,
  parameter int DUR_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [DUR_W-1:0] segLen,
  input  logic             busIn,
  output logic             segDone,
  output logic             shortFlag,
  output logic             presenceFlag
);

  localparam int PRESC_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRESC_W-1:0] PRESC_MAX = PRESC_W'(CLK_PER_US - 1);

  logic [PRESC_W-1:0] prescCnt;
  logic [DUR_W-1:0]   tickCnt;
  logic               usTick;
  logic               busSync;

  // Line synchronizer, depth set by parameter
  logic [SYNC_STAGES-1:0] syncReg;
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncReg[0] <= 1'b1;
          else       syncReg[0] <= busIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncReg[i] <= 1'b1;
          else       syncReg[i] <= syncReg[i-1];
        end
      end
    end
  endgenerate
  assign busSync = syncReg[SYNC_STAGES-1];

  // Microsecond prescaler
  assign usTick = (prescCnt == PRESC_MAX);
  always_ff @(posedge clk) begin
    if (!rstN || strb.restartTimer) prescCnt <= '0;
    else if (usTick)                prescCnt <= '0;
    else                            prescCnt <= prescCnt + 1'b1;
  end

  // Segment tick counter
  assign segDone = usTick && (tickCnt == segLen - 1'b1);
  always_ff @(posedge clk) begin
    if (!rstN || strb.restartTimer) tickCnt <= '0;
    else if (segDone)               tickCnt <= '0;
    else if (usTick)                tickCnt <= tickCnt + 1'b1;
  end

  // Result flags
  always_ff @(posedge clk) begin
    if (!rstN || strb.clearFlags) begin
      shortFlag    <= 1'b0;
      presenceFlag <= 1'b0;
    end else begin
      if (strb.sampleShort)    shortFlag    <= !busSync;
      if (strb.samplePresence) presenceFlag <= !busSync;
    end
  end

  assert_tick_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < segLen);
  assert_short_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clearFlags || strb.sampleShort) |=> $stable(shortFlag));
  assert_presence_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clearFlags || strb.samplePresence) |=> $stable(presenceFlag));
  assert_flags_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearFlags |=> (!shortFlag && !presenceFlag));

endmodule

// File: rtl/bus_reset_seq.sv
module bus_reset_seq
  import bus_reset_pkg::*;
#(
  parameter int CLK_PER_US  = 200,
  parameter int DUR_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int STD_LOW_US  = 512,
  parameter int STD_SI_US   = 8,
  parameter int STD_PDT_US  = 64,
  parameter int STD_FILL_US = 512,
  parameter int OD_LOW_US   = 64,
  parameter int OD_SI_US    = 2,
  parameter int OD_PDT_US   = 8,
  parameter int OD_FILL_US  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [1:0] speedSel,
  input  logic       busIn,
  output logic       pullLow,
  output logic       pullupEn,
  output logic       busy,
  output logic       done,
  output logic       shortFlag,
  output logic       presenceFlag
);

  dpStrobe_t        strb;
  logic [DUR_W-1:0] segLen;
  logic             segDone;

  bus_reset_ctrl #(
    .DUR_W(DUR_W),
    .STD_LOW_US(STD_LOW_US), .STD_SI_US(STD_SI_US),
    .STD_PDT_US(STD_PDT_US), .STD_FILL_US(STD_FILL_US),
    .OD_LOW_US(OD_LOW_US),   .OD_SI_US(OD_SI_US),
    .OD_PDT_US(OD_PDT_US),   .OD_FILL_US(OD_FILL_US)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .speedSel(speedSel),
    .segDone(segDone), .strb(strb), .segLen(segLen), .busy(busy),
    .pullLow(pullLow), .pullupEn(pullupEn), .done(done)
  );

  bus_reset_dp #(
    .CLK_PER_US(CLK_PER_US), .DUR_W(DUR_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .segLen(segLen), .busIn(busIn),
    .segDone(segDone), .shortFlag(shortFlag), .presenceFlag(presenceFlag)
  );

endmodule

// File: tb/tb_bus_reset_seq.sv
`timescale 1ns/1ps
module tb_bus_reset_seq;

  localparam int P = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] speedSel = 2'b00;
  logic busIn;
  logic pullLow, pullupEn, busy, done, shortFlag, presenceFlag;

  int checks = 0;
  int errors = 0;

  // Slave model: 0 none, 1 presence, 2 shorted line, 3 interrupt
  int slaveMode = 0;
  int curSi = 8;
  int curPdt = 64;
  int relCnt = 0;
  logic slaveLow;

  always #2.5 clk = ~clk;

  bus_reset_seq #(.CLK_PER_US(P)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .speedSel(speedSel),
    .busIn(busIn), .pullLow(pullLow), .pullupEn(pullupEn), .busy(busy),
    .done(done), .shortFlag(shortFlag), .presenceFlag(presenceFlag)
  );

  always @(posedge clk) relCnt <= pullupEn ? relCnt + 1 : 0;

  always_comb begin
    case (slaveMode)
      1: slaveLow = pullupEn && relCnt >= (curSi + 1) * P && relCnt < (curSi + 1 + curPdt) * P;
      2: slaveLow = 1'b1;
      3: slaveLow = pullupEn && relCnt < (curSi + 1) * P;
      default: slaveLow = 1'b0;
    endcase
  end
  assign busIn = !(pullLow || slaveLow);

  task automatic checkVal(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Run one sequence. Optionally inject a start strobe while busy, carrying another speed.
  task automatic runSeq(input logic [1:0] spd, input int mode, input logic expShort,
                        input logic expPres, input bit inject);
    int lowUs, highUs, lowCnt, highCnt, overlap;
    bit od;
    od = spd[1];
    lowUs  = od ? 64 : 512;
    highUs = od ? (2 + 8 + 64) : (8 + 64 + 512);
    @(negedge clk);
    slaveMode = mode;
    curSi  = od ? 2 : 8;
    curPdt = od ? 8 : 64;
    speedSel = spd;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    checkVal("R9 flags cleared after start (short)", shortFlag, 0);
    checkVal("R9 flags cleared after start (presence)", presenceFlag, 0);
    checkVal("R2 busy after start", busy, 1);
    lowCnt = 0; overlap = 0;
    while (pullLow && lowCnt < 20000) begin
      if (pullupEn) overlap++;
      lowCnt++;
      if (inject && lowCnt == 20) begin
        startReq = 1'b1;
        speedSel = ~spd;
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
    end
    startReq = 1'b0;
    checkVal("R2/R3/R10 low length", lowCnt, lowUs * P);
    highCnt = 0;
    while (pullupEn && highCnt < 20000) begin
      if (pullLow) overlap++;
      highCnt++;
      if (inject && highCnt == 40) startReq = 1'b1;
      else startReq = 1'b0;
      @(negedge clk);
    end
    startReq = 1'b0;
    checkVal("R4/R3/R8 high length", highCnt, highUs * P);
    checkVal("R4 no drive overlap", overlap, 0);
    checkVal("R7 done after fill", done, 1);
    checkVal("R7 busy low with done", busy, 0);
    checkVal("R5 short flag", shortFlag, expShort);
    checkVal("R6 presence flag", presenceFlag, expPres);
    @(negedge clk);
    checkVal("R7 done single cycle", done, 0);
    checkVal("R8 no restart after injected start", pullLow, 0);
  endtask

  // {speed[1:0], mode[1:0], expShort, expPresence}
  localparam logic [5:0] VEC [9] = '{
    {2'b00, 2'd0, 1'b0, 1'b0},
    {2'b00, 2'd1, 1'b0, 1'b1},
    {2'b00, 2'd2, 1'b1, 1'b1},
    {2'b00, 2'd3, 1'b1, 1'b0},
    {2'b10, 2'd1, 1'b0, 1'b1},
    {2'b10, 2'd2, 1'b1, 1'b1},
    {2'b10, 2'd3, 1'b1, 1'b0},
    {2'b01, 2'd1, 1'b0, 1'b1},
    {2'b11, 2'd0, 1'b0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    checkVal("R1 busy", busy, 0);
    checkVal("R1 done", done, 0);
    checkVal("R1 pullLow", pullLow, 0);
    checkVal("R1 pullupEn", pullupEn, 0);
    checkVal("R1 shortFlag", shortFlag, 0);
    checkVal("R1 presenceFlag", presenceFlag, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      runSeq(VEC[i][5:4], int'(VEC[i][3:2]), VEC[i][1], VEC[i][0], 1'b0);
    end

    // R8/R10: start injected while busy with a different speed mode
    runSeq(2'b00, 1, 1'b0, 1'b1, 1'b1);
    runSeq(2'b10, 2, 1'b1, 1'b1, 1'b1);

    // R9: flags hold while idle
    repeat (100) @(negedge clk);
    checkVal("R9 short held", shortFlag, 1);
    checkVal("R9 presence held", presenceFlag, 1);
    checkVal("R9 still idle", busy, 0);

    // R9: a new start clears the flags (checked inside runSeq)
    runSeq(2'b10, 0, 1'b0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule